// File: doc/BRIEF.md
# Register File with Precise Rollback

This block holds the 32 integer registers, each 32 bits wide, of an in-order-issue core whose instructions may finish out of order. Four combinational read ports serve operand fetch. Two write-back ports accept up to two results per clock. Every accepted write-back is speculative. Before the new value lands, the block saves the register's old contents in an 8-entry history buffer, tagged with the writer's sequence tag.

Retirement hands the block a tag. Every history entry whose tag is that old or older is released in one cycle, taken from the oldest end. A flush also hands the block a tag. Every entry younger than that tag is undone, newest first, at two entries per clock, which restores the architectural register values exactly. The undo begins in the cycle of the flush request. `busy_o` stays high while more entries remain to be undone.

Register 0 reads as zero on any read port whose base flag is set. This suits its use as an address base. Without the flag it is an ordinary register.

Top module: `hist_regfile`

## Requirements
- R1: After reset every register reads 0, the history buffer is empty, and `stall_o` and `busy_o` are low.
- R2: Each of the 4 read ports returns the register's current speculative value combinationally. A value written at a clock edge is visible from that edge on. It is not visible in the cycle its write is presented (no bypass).
- R3: A read of register 0 on a port whose base flag is 1 returns 0. With the flag at 0, register 0 returns its stored value.
- R4: Up to 2 writes are accepted per clock. If both ports name the same register, the register ends with port 1's data.
- R5: Each accepted write creates one history entry holding the register index, the value the register held before the write, and the write's tag. Port 0's entry comes before port 1's. When both ports name the same register, port 1's saved value is port 0's data, so undoing both restores the value from before the cycle.
- R6: `stall_o` is high when the buffer holds more than 6 of its 8 entries. A write presented while `stall_o`, `busy_o` or `flush_en_i` is high is dropped: it changes neither the register nor the history.
- R7: With `retire_en_i` high, every entry whose tag is not younger than `retire_tag_i` is released. The scan starts at the oldest entry and stops at the first younger one. A retire presented while `busy_o` or `flush_en_i` is high is ignored.
- R8: With `flush_en_i` high, every entry whose tag is younger than `flush_tag_i` is undone, newest first. Up to 2 entries are undone per clock, starting at the edge that samples the request. After an edge, `busy_o` is high if entries younger than the flush tag remain. A flush presented while `busy_o` is high is ignored.
- R9: Tags are 4-bit values compared modulo 16. Tag a is younger than tag b when (a - b) mod 16 lies in 1..7. For example, tag 1 is younger than tag 15, and tag 14 is not younger than tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_i | input | 4x5 | Register index for each read port |
| rd_base_i | input | 4 | Per read port: register 0 is an address base and reads as zero |
| rd_data_o | output | 4x32 | Read data for each port |
| wr_en_i | input | 2 | Write-back valid for each port |
| wr_addr_i | input | 2x5 | Destination register for each write port |
| wr_data_i | input | 2x32 | Write data for each port |
| wr_tag_i | input | 2x4 | Sequence tag of each writer |
| retire_en_i | input | 1 | Retire request |
| retire_tag_i | input | 4 | Youngest retiring tag |
| flush_en_i | input | 1 | Flush request |
| flush_tag_i | input | 4 | Entries younger than this tag are undone |
| stall_o | output | 1 | History nearly full; new writes are refused |
| busy_o | output | 1 | Undo still in progress |

## Verification
Retirement and write-back can fall in the same cycle. Retirement frees entries at the oldest end while allocation fills the newest end, so the history count must net both. The bench fills the buffer to 6 entries, then retires two of them while presenting two new writes. `stall_o` staying low shows the count came to 6 and not 8. A later flush with its cycle-by-cycle `busy_o` pattern and the restored register values shows that each entry landed in the right slot.

// File: rtl/hr_pkg.sv
package hr_pkg;
  localparam int unsigned HR_AW = 5;
  localparam int unsigned HR_DW = 32;
  localparam int unsigned HR_TW = 4;

  typedef struct packed {
    logic [HR_AW-1:0] addr;
    logic [HR_DW-1:0] old;
    logic [HR_TW-1:0] tag;
  } hist_ent_t;

  // a younger than b: modular distance in 1 .. 2^(TW-1)-1
  function automatic logic tag_younger(input logic [HR_TW-1:0] a, input logic [HR_TW-1:0] b);
    logic [HR_TW-1:0] d;
    d = a - b;
    return (d != '0) && !d[HR_TW-1];
  endfunction
endpackage

// File: rtl/hr_regs.sv
module hr_regs
  import hr_pkg::*;
#(
  parameter int unsigned NUM_RP = 6,
  parameter int unsigned NUM_WP = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_RP-1:0][HR_AW-1:0]  raddr_i,
  input  logic [NUM_RP-1:0]             rbase_i,
  output logic [NUM_RP-1:0][HR_DW-1:0]  rdata_o,
  input  logic [NUM_WP-1:0]             we_i,
  input  logic [NUM_WP-1:0][HR_AW-1:0]  waddr_i,
  input  logic [NUM_WP-1:0][HR_DW-1:0]  wdata_i
);
  localparam int unsigned NREG = 1 << HR_AW;

  logic [HR_DW-1:0] mem_q [NREG];

  // higher-numbered write port wins on a shared index
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else begin
      for (int p = 0; p < NUM_WP; p++)
        if (we_i[p]) mem_q[waddr_i[p]] <= wdata_i[p];
    end
  end

  for (genvar k = 0; k < NUM_RP; k++) begin : g_rd
    assign rdata_o[k] = (rbase_i[k] && raddr_i[k] == '0) ? '0 : mem_q[raddr_i[k]];
  end
endmodule

// File: rtl/hr_hist.sv
module hr_hist
  import hr_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned NUM_WR = 2,
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic      [NUM_WR-1:0]  alloc_i,
  input  hist_ent_t [NUM_WR-1:0]  alloc_ent_i,
  input  logic                    retire_en_i,
  input  logic      [HR_TW-1:0]   retire_tag_i,
  input  logic                    flush_en_i,
  input  logic      [HR_TW-1:0]   flush_tag_i,
  output logic      [NUM_WR-1:0]  undo_we_o,
  output hist_ent_t [NUM_WR-1:0]  undo_ent_o,
  output logic                    stall_o,
  output logic                    busy_o,
  output logic      [CW-1:0]      cnt_o
);
  hist_ent_t           ent_q [DEPTH];
  logic [PW-1:0]       head_q;
  logic [CW-1:0]       cnt_q;
  logic                busy_q;
  logic [HR_TW-1:0]    ftag_q;

  logic [PW-1:0]       tail;
  logic [NUM_WR-1:0][PW-1:0] aidx;
  int unsigned         n_alloc, n_ret, n_pop;
  logic                undo_act, more;
  logic [HR_TW-1:0]    cur_ftag;

  assign tail     = head_q + PW'(cnt_q);
  assign undo_act = busy_q | flush_en_i;
  assign cur_ftag = busy_q ? ftag_q : flush_tag_i;

  // allocation slots, port order
  always_comb begin
    n_alloc = 0;
    for (int p = 0; p < NUM_WR; p++) begin
      aidx[p] = tail + PW'(n_alloc);
      if (alloc_i[p]) n_alloc = n_alloc + 1;
    end
  end

  // undo scan from newest end
  always_comb begin
    logic go;
    logic [PW-1:0] idx;
    go         = 1'b1;
    n_pop      = 0;
    undo_we_o  = '0;
    undo_ent_o = '0;
    for (int j = 0; j < NUM_WR; j++) begin
      idx = head_q + PW'(cnt_q) - PW'(j + 1);
      if (undo_act && go && (CW'(j) < cnt_q) && tag_younger(ent_q[idx].tag, cur_ftag)) begin
        undo_we_o[j]  = 1'b1;
        undo_ent_o[j] = ent_q[idx];
        n_pop         = n_pop + 1;
      end else begin
        go = 1'b0;
      end
    end
    idx  = head_q + PW'(cnt_q) - PW'(n_pop + 1);
    more = undo_act && (cnt_q > CW'(n_pop)) && tag_younger(ent_q[idx].tag, cur_ftag);
  end

  // retire scan from oldest end
  always_comb begin
    logic rgo;
    logic [PW-1:0] idx;
    rgo   = retire_en_i && !undo_act;
    n_ret = 0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = head_q + PW'(i);
      if (rgo && (CW'(i) < cnt_q) && !tag_younger(ent_q[idx].tag, retire_tag_i))
        n_ret = n_ret + 1;
      else
        rgo = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      head_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      ftag_q <= '0;
    end else begin
      for (int p = 0; p < NUM_WR; p++)
        if (alloc_i[p]) ent_q[aidx[p]] <= alloc_ent_i[p];
      head_q <= head_q + PW'(n_ret);
      cnt_q  <= cnt_q + CW'(n_alloc) - CW'(n_ret) - CW'(n_pop);
      busy_q <= more;
      if (flush_en_i && !busy_q) ftag_q <= flush_tag_i;
    end
  end

  assign stall_o = cnt_q > CW'(DEPTH - NUM_WR);
  assign busy_o  = busy_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/hist_regfile.sv
module hist_regfile
  import hr_pkg::*;
#(
  parameter int unsigned HIST_DEPTH = 8,
  parameter int unsigned NUM_RD     = 4,
  parameter int unsigned NUM_WR     = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_RD-1:0][HR_AW-1:0]  rd_addr_i,
  input  logic [NUM_RD-1:0]             rd_base_i,
  output logic [NUM_RD-1:0][HR_DW-1:0]  rd_data_o,
  input  logic [NUM_WR-1:0]             wr_en_i,
  input  logic [NUM_WR-1:0][HR_AW-1:0]  wr_addr_i,
  input  logic [NUM_WR-1:0][HR_DW-1:0]  wr_data_i,
  input  logic [NUM_WR-1:0][HR_TW-1:0]  wr_tag_i,
  input  logic                          retire_en_i,
  input  logic [HR_TW-1:0]              retire_tag_i,
  input  logic                          flush_en_i,
  input  logic [HR_TW-1:0]              flush_tag_i,
  output logic                          stall_o,
  output logic                          busy_o
);
  localparam int unsigned NRP = NUM_RD + NUM_WR;
  localparam int unsigned NWP = 2 * NUM_WR;
  localparam int unsigned CW  = $clog2(HIST_DEPTH + 1);

  logic                       stall, busy;
  logic [CW-1:0]              hist_cnt;
  logic [NUM_WR-1:0]          wb_acc, undo_we;
  hist_ent_t [NUM_WR-1:0]     alloc_ent, undo_ent;
  logic [NRP-1:0][HR_AW-1:0]  rp_addr;
  logic [NRP-1:0]             rp_base;
  logic [NRP-1:0][HR_DW-1:0]  rp_data;
  logic [NWP-1:0]             wp_en;
  logic [NWP-1:0][HR_AW-1:0]  wp_addr;
  logic [NWP-1:0][HR_DW-1:0]  wp_data;

  // extra read ports fetch the values about to be overwritten
  assign rp_addr   = {wr_addr_i, rd_addr_i};
  assign rp_base   = {{NUM_WR{1'b0}}, rd_base_i};
  assign rd_data_o = rp_data[NUM_RD-1:0];

  assign wb_acc = wr_en_i & {NUM_WR{~stall & ~busy & ~flush_en_i}};

  always_comb begin
    logic [HR_DW-1:0] prior;
    for (int p = 0; p < NUM_WR; p++) begin
      prior = rp_data[NUM_RD+p];
      for (int q = 0; q < p; q++)
        if (wb_acc[q] && wr_addr_i[q] == wr_addr_i[p]) prior = wr_data_i[q];
      alloc_ent[p].addr = wr_addr_i[p];
      alloc_ent[p].old  = prior;
      alloc_ent[p].tag  = wr_tag_i[p];
    end
  end

  // undo ports first (newest at 0), write-back after; later index wins
  always_comb begin
    wp_en = {wb_acc, undo_we};
    for (int p = 0; p < NUM_WR; p++) begin
      wp_addr[p]        = undo_ent[p].addr;
      wp_data[p]        = undo_ent[p].old;
      wp_addr[NUM_WR+p] = wr_addr_i[p];
      wp_data[NUM_WR+p] = wr_data_i[p];
    end
  end

  hr_regs #(.NUM_RP(NRP), .NUM_WP(NWP)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (rp_addr),
    .rbase_i (rp_base),
    .rdata_o (rp_data),
    .we_i    (wp_en),
    .waddr_i (wp_addr),
    .wdata_i (wp_data)
  );

  hr_hist #(.DEPTH(HIST_DEPTH), .NUM_WR(NUM_WR)) u_hist (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (wb_acc),
    .alloc_ent_i  (alloc_ent),
    .retire_en_i  (retire_en_i),
    .retire_tag_i (retire_tag_i),
    .flush_en_i   (flush_en_i),
    .flush_tag_i  (flush_tag_i),
    .undo_we_o    (undo_we),
    .undo_ent_o   (undo_ent),
    .stall_o      (stall),
    .busy_o       (busy),
    .cnt_o        (hist_cnt)
  );

  assign stall_o = stall;
  assign busy_o  = busy;
endmodule

// File: rtl/hr_checker.sv
module hr_checker
  import hr_pkg::*;
#(
  parameter int unsigned HIST_DEPTH = 8,
  parameter int unsigned NUM_RD     = 4,
  parameter int unsigned NUM_WR     = 2,
  localparam int unsigned CW        = $clog2(HIST_DEPTH + 1)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_RD-1:0][HR_AW-1:0]  rd_addr_i,
  input logic [NUM_RD-1:0]             rd_base_i,
  input logic [NUM_RD-1:0][HR_DW-1:0]  rd_data_o,
  input logic [NUM_WR-1:0]             wr_en_i,
  input logic                          retire_en_i,
  input logic                          flush_en_i,
  input logic                          stall_o,
  input logic                          busy_o,
  input logic [CW-1:0]                 cnt_i
);
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(HIST_DEPTH));

  p_stall_no_alloc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> cnt_i <= $past(cnt_i));

  p_dual_alloc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && !busy_o && !flush_en_i && !retire_en_i && (&wr_en_i))
      |=> cnt_i == $past(cnt_i) + CW'(NUM_WR));

  p_undo_progress_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> cnt_i < $past(cnt_i));

  p_busy_has_work_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_i != '0);

  for (genvar k = 0; k < NUM_RD; k++) begin : g_base
    p_base_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_base_i[k] && rd_addr_i[k] == '0) |-> rd_data_o[k] == '0);
  end
endmodule

bind hist_regfile hr_checker #(
  .HIST_DEPTH (HIST_DEPTH),
  .NUM_RD     (NUM_RD),
  .NUM_WR     (NUM_WR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_addr_i   (rd_addr_i),
  .rd_base_i   (rd_base_i),
  .rd_data_o   (rd_data_o),
  .wr_en_i     (wr_en_i),
  .retire_en_i (retire_en_i),
  .flush_en_i  (flush_en_i),
  .stall_o     (stall_o),
  .busy_o      (busy_o),
  .cnt_i       (hist_cnt)
);

// File: tb/tb_hist_regfile.sv
`timescale 1ns/1ps
module tb_hist_regfile;
  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [3:0][4:0]  rd_addr = '0;
  logic [3:0]       rd_base = '0;
  logic [3:0][31:0] rd_data;
  logic [1:0]       wr_en = '0;
  logic [1:0][4:0]  wr_addr = '0;
  logic [1:0][31:0] wr_data = '0;
  logic [1:0][3:0]  wr_tag = '0;
  logic             retire_en = 1'b0;
  logic [3:0]       retire_tag = '0;
  logic             flush_en = 1'b0;
  logic [3:0]       flush_tag = '0;
  logic             stall_o, busy_o;
  int               n_checks = 0;
  int               n_errors = 0;

  always #5 clk_i = ~clk_i;

  hist_regfile dut (
    .clk_i, .rst_ni,
    .rd_addr_i (rd_addr), .rd_base_i (rd_base), .rd_data_o (rd_data),
    .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data), .wr_tag_i (wr_tag),
    .retire_en_i (retire_en), .retire_tag_i (retire_tag),
    .flush_en_i (flush_en), .flush_tag_i (flush_tag),
    .stall_o, .busy_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    wr_en = '0; retire_en = 1'b0; flush_en = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk_i); #1; idle_in();
  endtask

  task automatic set_wr(input int p, input int a, input logic [31:0] d, input int t);
    wr_en[p] = 1'b1; wr_addr[p] = 5'(a); wr_data[p] = d; wr_tag[p] = 4'(t);
  endtask

  task automatic chk_reg(input string req, input int a, input logic [31:0] exp);
    rd_addr[0] = 5'(a); rd_base[0] = 1'b0; #0.2;
    chk(req, rd_data[0], exp);
  endtask

  task automatic do_reset();
    idle_in(); rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    tick();
  endtask

  task automatic t_reset_r1();
    do_reset();
    for (int a = 0; a < 32; a++) chk_reg("R1 reg zero", a, 32'h0);
    chk("R1 stall low", 32'(stall_o), 0);
    chk("R1 busy low", 32'(busy_o), 0);
  endtask

  task automatic t_rw_r2();
    do_reset();
    set_wr(0, 5, 32'hA5A5_0005, 1); set_wr(1, 9, 32'h5A5A_0009, 1);
    chk_reg("R2 no bypass", 5, 32'h0);
    tick();
    rd_addr = {5'd9, 5'd5, 5'd9, 5'd5}; rd_base = '0; #0.2;
    for (int k = 0; k < 4; k++)
      chk("R2 R4 read port", rd_data[k], (k % 2 == 0) ? 32'hA5A5_0005 : 32'h5A5A_0009);
  endtask

  task automatic t_r0_r3();
    do_reset();
    set_wr(0, 0, 32'h0000_1234, 1); tick();
    rd_addr = '0; rd_base = 4'b1010; #0.2;
    chk("R3 base flag zero", rd_data[1], 32'h0);
    chk("R3 plain r0", rd_data[0], 32'h0000_1234);
    chk("R3 base flag zero p3", rd_data[3], 32'h0);
    rd_base = '0;
  endtask

  task automatic t_collide_r5();
    do_reset();
    set_wr(0, 3, 32'h11, 1); tick();
    retire_en = 1'b1; retire_tag = 4'd1; tick();
    set_wr(0, 3, 32'h22, 2); set_wr(1, 3, 32'h33, 2); tick();
    chk_reg("R4 port1 wins", 3, 32'h33);
    flush_en = 1'b1; flush_tag = 4'd2; tick();
    chk_reg("R8 flush same tag no undo", 3, 32'h33);
    flush_en = 1'b1; flush_tag = 4'd1; tick();
    chk_reg("R5 ordered undo", 3, 32'h11);
    chk("R8 busy done", 32'(busy_o), 0);
  endtask

  task automatic t_stall_r6();
    do_reset();
    set_wr(0, 1, 32'h1, 1); set_wr(1, 2, 32'h2, 1); tick();
    set_wr(0, 3, 32'h3, 2); set_wr(1, 4, 32'h4, 2); tick();
    set_wr(0, 5, 32'h5, 3); set_wr(1, 6, 32'h6, 3); tick();
    chk("R6 six entries no stall", 32'(stall_o), 0);
    set_wr(0, 7, 32'h7, 4); tick();
    chk("R6 seven entries stall", 32'(stall_o), 1);
    set_wr(0, 8, 32'hBAD, 5); tick();
    chk_reg("R6 write dropped on stall", 8, 32'h0);
    retire_en = 1'b1; retire_tag = 4'd1; tick();
    chk("R7 retire frees", 32'(stall_o), 0);
    set_wr(0, 8, 32'h88, 5); tick();
    chk_reg("R6 write after retire", 8, 32'h88);
    flush_en = 1'b1; flush_tag = 4'd3; set_wr(0, 10, 32'hAA, 6); tick();
    chk_reg("R8 undo r7", 7, 32'h0);
    chk_reg("R8 undo r8", 8, 32'h0);
    chk_reg("R6 write dropped on flush", 10, 32'h0);
    chk_reg("R8 older kept", 5, 32'h5);
    chk("R8 no busy", 32'(busy_o), 0);
  endtask

  task automatic t_multi_r8();
    do_reset();
    set_wr(0, 1, 32'h101, 1); set_wr(1, 2, 32'h102, 1); tick();
    set_wr(0, 1, 32'h201, 2); set_wr(1, 3, 32'h203, 2); tick();
    set_wr(0, 2, 32'h302, 3); set_wr(1, 1, 32'h301, 3); tick();
    flush_en = 1'b1; flush_tag = 4'd0; tick();
    chk("R8 busy after step1", 32'(busy_o), 1);
    chk_reg("R8 step1 r1", 1, 32'h201);
    chk_reg("R8 step1 r2", 2, 32'h102);
    chk_reg("R8 step1 r3", 3, 32'h203);
    set_wr(0, 20, 32'hDEAD, 7); tick();
    chk("R8 busy after step2", 32'(busy_o), 1);
    chk_reg("R8 step2 r1", 1, 32'h101);
    chk_reg("R8 step2 r3", 3, 32'h0);
    tick();
    chk("R8 busy cleared", 32'(busy_o), 0);
    chk_reg("R8 step3 r1", 1, 32'h0);
    chk_reg("R8 step3 r2", 2, 32'h0);
    chk_reg("R6 write dropped when busy", 20, 32'h0);
  endtask

  task automatic t_wrap_r9();
    do_reset();
    set_wr(0, 4, 32'h44, 14); tick();
    set_wr(0, 5, 32'h55, 1); tick();
    retire_en = 1'b1; retire_tag = 4'd0; tick();
    flush_en = 1'b1; flush_tag = 4'd13; tick();
    chk_reg("R9 R7 wrapped retire kept", 4, 32'h44);
    chk_reg("R9 wrapped younger undone", 5, 32'h0);
    do_reset();
    set_wr(0, 4, 32'h44, 14); tick();
    set_wr(0, 5, 32'h55, 1); tick();
    flush_en = 1'b1; flush_tag = 4'd15; tick();
    chk_reg("R9 tag14 older than 15", 4, 32'h44);
    chk_reg("R9 tag1 younger than 15", 5, 32'h0);
  endtask

  task automatic t_ret_wb_r7();
    do_reset();
    set_wr(0, 1, 32'h1001, 1); set_wr(1, 2, 32'h1002, 1); tick();
    set_wr(0, 3, 32'h1003, 2); set_wr(1, 4, 32'h1004, 2); tick();
    set_wr(0, 5, 32'h1005, 3); set_wr(1, 6, 32'h1006, 3); tick();
    retire_en = 1'b1; retire_tag = 4'd1;
    set_wr(0, 10, 32'h1010, 4); set_wr(1, 11, 32'h1011, 4); tick();
    chk("R7 retire with writes no stall", 32'(stall_o), 0);
    chk_reg("R7 write during retire", 10, 32'h1010);
    set_wr(0, 12, 32'h1012, 5); tick();
    chk("R6 stall at seven", 32'(stall_o), 1);
    flush_en = 1'b1; flush_tag = 4'd1; tick();
    chk("R8 busy 1", 32'(busy_o), 1);
    tick(); chk("R8 busy 2", 32'(busy_o), 1);
    tick(); chk("R8 busy 3", 32'(busy_o), 1);
    tick(); chk("R8 busy end", 32'(busy_o), 0);
    chk_reg("R7 retired r1 kept", 1, 32'h1001);
    chk_reg("R7 retired r2 kept", 2, 32'h1002);
    chk_reg("R8 r3 undone", 3, 32'h0);
    chk_reg("R8 r10 undone", 10, 32'h0);
    chk_reg("R8 r12 undone", 12, 32'h0);
    chk("R6 stall released", 32'(stall_o), 0);
  endtask

  initial begin
    t_reset_r1();
    t_rw_r2();
    t_r0_r3();
    t_collide_r5();
    t_stall_r6();
    t_multi_r8();
    t_wrap_r9();
    t_ret_wb_r7();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #500000;
    n_checks++; n_errors++;
    $display("FAIL watchdog all R actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule